// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor's memory port and its cache controller. It records every request that has been issued and has not yet completed. Each cache line can have at most one such request, and the requests are kept in two tables. The read table holds plain loads and instruction fetches. The write table holds every type that needs ownership of the line. When a new request is presented, the tracker answers with one of four results: issued, aliased (a request to the same line is already outstanding), full, or illegal. Only an issued request is recorded with the time it was issued and passed on as a coherence command, together with the access-mode and latency hints it needs.

A completion names a line address and a class bit, and it frees the matching entry. A completion that matches no entry raises a one-cycle error pulse. Aliased requests are counted in four stall counters, split by the kind of entry that blocked them and the kind of request that was blocked. A periodic age watchdog runs while anything is outstanding. If it finds an entry that has waited too long, it latches a sticky deadlock flag with that line and its table. From then on the block stops accepting requests.

Top module: `mreq_tracker`

## Requirements
- R1: Request kind codes are load=0 and fetch=1, which are read class, and store=2, read-modify-write read=3, read-modify-write write=4, linked load=5, conditional store=6, locked RMW read=7 and locked RMW write=8, which are write class. An issued request occupies an entry in the table of its class, and a completion must name the same class to retire it.
- R2: If the request's line has a write-table entry, the status is aliased (1). A load, fetch or RMW read then adds one to `stl_wload`, and any other kind adds one to `stl_wstore`.
- R3: If only the read table holds the line, the status is aliased (1). A store or RMW write then adds one to `stl_rstore`, and any other kind adds one to `stl_rload`.
- R4: A request that does not alias gets status full (2) when `outstanding` is at least MAX_OUT or when its class table has no free slot. Nothing is recorded in that case.
- R5: `outstanding` always equals the number of occupied entries in both tables. It rises by one for each issued request and falls by one for each retired entry, and both can happen in the same cycle.
- R6: An issued request (status 0) drives `cmd_op` as follows: fetch gives 0 (fetch), load gives 1 (load), kinds 2, 3, 4, 7 and 8 give 2 (exclusive), and kinds 5 and 6 give 3 (atomic). `cmd_line` carries the line address.
- R7: `cmd_mode` passes user (0) and supervisor (1) through unchanged. Device (2) and the reserved code 3 are sent as user (0).
- R8: `cmd_lat` is ILAT for a fetch and DLAT for every other kind.
- R9: A request whose byte offset within the line plus `req_len` exceeds LINE_BYTES, or whose kind code is above 8, gets status illegal (3). It records nothing and changes no counter.
- R10: A completion removes the entry of its class whose line matches. If no such entry exists, `cpl_err` is high for one cycle.
- R11: The first insert into an idle tracker arms a check that runs THRESH cycles later and then every THRESH cycles while entries remain. A check that finds an entry aged THRESH or more sets `dl_flag` for good and latches that entry's line in `dl_line` and its class in `dl_is_write`, with the read table taking priority.
- R12: While `dl_flag` is set, `req_ready` is low, requests are ignored and no response is given.
- R13: A request is judged against the tables as they stand before any completion in the same cycle. An alias with a line that is retiring in that cycle is still reported, and the full test uses the count from before the retirement.
- R14: Every accepted handshake gives `rsp_valid` with its status in the next cycle. For an issued request, `cmd_valid` and its command fields appear in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Tracker accepts requests (low after deadlock) |
| req_kind | input | 4 | Request kind code |
| req_addr | input | AW | Byte address |
| req_len | input | OFFW+1 | Access length in bytes |
| req_mode | input | 2 | Access mode: 0 user, 1 supervisor, 2 device |
| rsp_valid | output | 1 | Status of the previous cycle's request is valid |
| rsp_status | output | 2 | 0 issued, 1 aliased, 2 full, 3 illegal |
| cmd_valid | output | 1 | Coherence command issued |
| cmd_op | output | 2 | 0 fetch, 1 load, 2 exclusive, 3 atomic |
| cmd_line | output | AW-OFFW | Line address of the command |
| cmd_mode | output | 2 | Forwarded access mode |
| cmd_lat | output | LATW | Cache latency hint |
| cpl_valid | input | 1 | Completion present |
| cpl_line | input | AW-OFFW | Completed line address |
| cpl_is_write | input | 1 | Completion belongs to the write table |
| cpl_err | output | 1 | Completion matched no entry |
| outstanding | output | CW | Number of occupied entries |
| stl_wload | output | SCW | Write entry blocked a load-like request |
| stl_wstore | output | SCW | Write entry blocked another request |
| stl_rstore | output | SCW | Read entry blocked a store-like request |
| stl_rload | output | SCW | Read entry blocked another request |
| dl_flag | output | 1 | Sticky deadlock flag |
| dl_line | output | AW-OFFW | Line of the over-age entry |
| dl_is_write | output | 1 | Table of the over-age entry |

## Verification
The tricky overlap is a new request and a completion arriving in the same cycle. The request is judged against the tables before the retirement, while the count and the tables take both changes at once. The bench provokes this directly in three ways: it requests a line whose completion is in flight, which must still report aliased, and it requests while at MAX_OUT with one retirement pending, which must report full. It also provokes it heavily in a random phase where a completion of an existing entry appears on most cycles. A behavioural model built on queues predicts the status, the command, the count and every stall counter on each clock, so any wrong ordering of the two actions shows up as a mismatch on that cycle.

// File: rtl/mreq_pkg.sv
package mreq_pkg;
  timeunit 1ns; timeprecision 1ps;

  localparam logic [3:0] RQ_LOAD      = 4'd0;
  localparam logic [3:0] RQ_FETCH     = 4'd1;
  localparam logic [3:0] RQ_STORE     = 4'd2;
  localparam logic [3:0] RQ_RMW_RD    = 4'd3;
  localparam logic [3:0] RQ_RMW_WR    = 4'd4;
  localparam logic [3:0] RQ_LINK_LD   = 4'd5;
  localparam logic [3:0] RQ_COND_ST   = 4'd6;
  localparam logic [3:0] RQ_LK_RMW_RD = 4'd7;
  localparam logic [3:0] RQ_LK_RMW_WR = 4'd8;

  localparam logic [1:0] CMD_FETCH  = 2'd0;
  localparam logic [1:0] CMD_LOAD   = 2'd1;
  localparam logic [1:0] CMD_EXCL   = 2'd2;
  localparam logic [1:0] CMD_ATOMIC = 2'd3;

  localparam logic [1:0] MODE_USER  = 2'd0;
  localparam logic [1:0] MODE_SUPER = 2'd1;

  localparam logic [1:0] ST_ISSUED  = 2'd0;
  localparam logic [1:0] ST_ALIAS   = 2'd1;
  localparam logic [1:0] ST_FULL    = 2'd2;
  localparam logic [1:0] ST_ILLEGAL = 2'd3;
endpackage

// File: rtl/mreq_kind_decode.sv
module mreq_kind_decode
  import mreq_pkg::*;
#(
  parameter int LATW = 4,
  parameter int ILAT = 1,
  parameter int DLAT = 2
) (
  input  logic [3:0]      kind,
  input  logic [1:0]      mode_in,
  output logic            known,
  output logic            wr_class,
  output logic            load_like,
  output logic            store_like,
  output logic [1:0]      op,
  output logic [1:0]      mode_out,
  output logic [LATW-1:0] lat
);
  timeunit 1ns; timeprecision 1ps;

  always_comb begin
    known      = 1'b1;
    wr_class   = 1'b1;
    load_like  = 1'b0;
    store_like = 1'b0;
    op         = CMD_EXCL;
    unique case (kind)
      RQ_LOAD:  begin wr_class = 1'b0; load_like = 1'b1; op = CMD_LOAD;  end
      RQ_FETCH: begin wr_class = 1'b0; load_like = 1'b1; op = CMD_FETCH; end
      RQ_STORE:   store_like = 1'b1;
      RQ_RMW_RD:  load_like  = 1'b1;
      RQ_RMW_WR:  store_like = 1'b1;
      RQ_LINK_LD, RQ_COND_ST: op = CMD_ATOMIC;
      RQ_LK_RMW_RD, RQ_LK_RMW_WR: op = CMD_EXCL;
      default: known = 1'b0;
    endcase
  end

  assign mode_out = (mode_in == MODE_SUPER) ? MODE_SUPER : MODE_USER;
  assign lat      = (kind == RQ_FETCH) ? LATW'(ILAT) : LATW'(DLAT);
endmodule

// File: rtl/mreq_line_table.sv
module mreq_line_table #(
  parameter int DEPTH  = 8,
  parameter int LW     = 26,
  parameter int TSW    = 16,
  parameter int THRESH = 1000,
  parameter int CW     = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [LW-1:0]  probe_line,
  output logic           probe_hit,
  input  logic           ret_en,
  input  logic [LW-1:0]  ret_line,
  output logic           ret_hit,
  input  logic           ins_en,
  input  logic [LW-1:0]  ins_line,
  input  logic [TSW-1:0] now,
  output logic           has_free,
  output logic [CW-1:0]  occ,
  output logic           old_any,
  output logic [LW-1:0]  old_line
);
  timeunit 1ns; timeprecision 1ps;

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld_q, probe_m, ret_m, old_m;
  logic [LW-1:0]    line_q [DEPTH];
  logic [TSW-1:0]   ts_q   [DEPTH];
  logic [IW-1:0]    free_idx, ret_idx, old_idx;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [TSW-1:0] age;
    assign age        = now - ts_q[g];
    assign probe_m[g] = vld_q[g] && (line_q[g] == probe_line);
    assign ret_m[g]   = vld_q[g] && (line_q[g] == ret_line);
    assign old_m[g]   = vld_q[g] && (age >= TSW'(THRESH));
  end

  // lowest-index priority for every search
  always_comb begin
    free_idx = '0;
    ret_idx  = '0;
    old_idx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!vld_q[i]) free_idx = IW'(i);
      if (ret_m[i])  ret_idx  = IW'(i);
      if (old_m[i])  old_idx  = IW'(i);
    end
  end

  assign probe_hit = |probe_m;
  assign ret_hit   = |ret_m;
  assign has_free  = ~&vld_q;
  assign old_any   = |old_m;
  assign old_line  = line_q[old_idx];
  assign occ       = CW'($countones(vld_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= '0;
    end else begin
      if (ret_en && ret_hit) vld_q[ret_idx]  <= 1'b0;
      if (ins_en)            vld_q[free_idx] <= 1'b1;
    end
  end

  // payload kept without reset so it maps onto plain storage
  always_ff @(posedge clk) begin
    if (ins_en) begin
      line_q[free_idx] <= ins_line;
      ts_q[free_idx]   <= now;
    end
  end
endmodule

// File: rtl/mreq_age_watch.sv
module mreq_age_watch #(
  parameter int THRESH = 1000,
  parameter int TMW    = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic busy_next,
  output logic check
);
  timeunit 1ns; timeprecision 1ps;

  logic           armed_q;
  logic [TMW-1:0] tmr_q;

  assign check = armed_q && (tmr_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      tmr_q   <= '0;
    end else if (check) begin
      armed_q <= busy_next;
      tmr_q   <= TMW'(THRESH - 1);
    end else if (armed_q) begin
      tmr_q   <= tmr_q - 1'b1;
    end else if (arm) begin
      armed_q <= 1'b1;
      tmr_q   <= TMW'(THRESH - 1);
    end
  end
endmodule

// File: rtl/mreq_tracker.sv
module mreq_tracker
  import mreq_pkg::*;
#(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH      = 8,
  parameter int MAX_OUT    = 12,
  parameter int THRESH     = 1000,
  parameter int TSW        = 16,
  parameter int LATW       = 4,
  parameter int ILAT       = 1,
  parameter int DLAT       = 2,
  parameter int SCW        = 16,
  localparam int OFFW      = $clog2(LINE_BYTES),
  localparam int LW        = AW - OFFW,
  localparam int LENW      = OFFW + 1,
  localparam int CW        = $clog2(2 * DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [3:0]      req_kind,
  input  logic [AW-1:0]   req_addr,
  input  logic [LENW-1:0] req_len,
  input  logic [1:0]      req_mode,
  output logic            rsp_valid,
  output logic [1:0]      rsp_status,
  output logic            cmd_valid,
  output logic [1:0]      cmd_op,
  output logic [LW-1:0]   cmd_line,
  output logic [1:0]      cmd_mode,
  output logic [LATW-1:0] cmd_lat,
  input  logic            cpl_valid,
  input  logic [LW-1:0]   cpl_line,
  input  logic            cpl_is_write,
  output logic            cpl_err,
  output logic [CW-1:0]   outstanding,
  output logic [SCW-1:0]  stl_wload,
  output logic [SCW-1:0]  stl_wstore,
  output logic [SCW-1:0]  stl_rstore,
  output logic [SCW-1:0]  stl_rload,
  output logic            dl_flag,
  output logic [LW-1:0]   dl_line,
  output logic            dl_is_write
);
  timeunit 1ns; timeprecision 1ps;

  localparam int SW  = LENW + 1;
  localparam int TMW = $clog2(THRESH + 1);

  logic [LW-1:0]   req_line;
  logic [SW-1:0]   span;
  logic            len_ok;
  logic            d_known, d_wr, d_ldlike, d_stlike;
  logic [1:0]      d_op, d_mode;
  logic [LATW-1:0] d_lat;

  logic            rd_probe, wr_probe, rd_ret, wr_ret, rd_free, wr_free;
  logic            rd_old, wr_old, check;
  logic [LW-1:0]   rd_old_line, wr_old_line;
  logic [CW-1:0]   rd_occ, wr_occ, cnt_q, cnt_nxt;
  logic [TSW-1:0]  time_q;
  logic            take, accept, retired, tgt_free, valid_req;
  logic [1:0]      status;

  assign req_line  = req_addr[AW-1:OFFW];
  assign span      = SW'(req_addr[OFFW-1:0]) + SW'(req_len);
  assign len_ok    = span <= SW'(LINE_BYTES);
  assign req_ready = ~dl_flag;
  assign take      = req_valid && req_ready;

  mreq_kind_decode #(.LATW(LATW), .ILAT(ILAT), .DLAT(DLAT)) u_dec (
    .kind(req_kind), .mode_in(req_mode), .known(d_known), .wr_class(d_wr),
    .load_like(d_ldlike), .store_like(d_stlike), .op(d_op), .mode_out(d_mode),
    .lat(d_lat)
  );

  assign valid_req = d_known && len_ok;
  assign tgt_free  = d_wr ? wr_free : rd_free;

  always_comb begin
    status = ST_ISSUED;
    if (!valid_req)                               status = ST_ILLEGAL;
    else if (wr_probe || rd_probe)                status = ST_ALIAS;
    else if (cnt_q >= CW'(MAX_OUT) || !tgt_free)  status = ST_FULL;
  end

  assign accept  = take && (status == ST_ISSUED);
  assign retired = cpl_valid && (cpl_is_write ? wr_ret : rd_ret);
  assign cnt_nxt = cnt_q + CW'(accept) - CW'(retired);

  mreq_line_table #(.DEPTH(DEPTH), .LW(LW), .TSW(TSW), .THRESH(THRESH), .CW(CW)) u_rd_tab (
    .clk(clk), .rst(rst), .probe_line(req_line), .probe_hit(rd_probe),
    .ret_en(cpl_valid && !cpl_is_write), .ret_line(cpl_line), .ret_hit(rd_ret),
    .ins_en(accept && !d_wr), .ins_line(req_line), .now(time_q),
    .has_free(rd_free), .occ(rd_occ), .old_any(rd_old), .old_line(rd_old_line)
  );

  mreq_line_table #(.DEPTH(DEPTH), .LW(LW), .TSW(TSW), .THRESH(THRESH), .CW(CW)) u_wr_tab (
    .clk(clk), .rst(rst), .probe_line(req_line), .probe_hit(wr_probe),
    .ret_en(cpl_valid && cpl_is_write), .ret_line(cpl_line), .ret_hit(wr_ret),
    .ins_en(accept && d_wr), .ins_line(req_line), .now(time_q),
    .has_free(wr_free), .occ(wr_occ), .old_any(wr_old), .old_line(wr_old_line)
  );

  mreq_age_watch #(.THRESH(THRESH), .TMW(TMW)) u_watch (
    .clk(clk), .rst(rst), .arm(accept), .busy_next(cnt_nxt != '0), .check(check)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_status  <= ST_ISSUED;
      cmd_valid   <= 1'b0;
      cmd_op      <= CMD_FETCH;
      cmd_line    <= '0;
      cmd_mode    <= MODE_USER;
      cmd_lat     <= '0;
      cpl_err     <= 1'b0;
      cnt_q       <= '0;
      time_q      <= '0;
      stl_wload   <= '0;
      stl_wstore  <= '0;
      stl_rstore  <= '0;
      stl_rload   <= '0;
      dl_flag     <= 1'b0;
      dl_line     <= '0;
      dl_is_write <= 1'b0;
    end else begin
      rsp_valid <= take;
      if (take) rsp_status <= status;
      cmd_valid <= accept;
      if (accept) begin
        cmd_op   <= d_op;
        cmd_line <= req_line;
        cmd_mode <= d_mode;
        cmd_lat  <= d_lat;
      end
      cpl_err <= cpl_valid && !retired;
      cnt_q   <= cnt_nxt;
      time_q  <= time_q + 1'b1;
      if (take && valid_req) begin
        if (wr_probe) begin
          if (d_ldlike) stl_wload  <= stl_wload + 1'b1;
          else          stl_wstore <= stl_wstore + 1'b1;
        end else if (rd_probe) begin
          if (d_stlike) stl_rstore <= stl_rstore + 1'b1;
          else          stl_rload  <= stl_rload + 1'b1;
        end
      end
      if (check && !dl_flag && (rd_old || wr_old)) begin
        dl_flag     <= 1'b1;
        dl_line     <= rd_old ? rd_old_line : wr_old_line;
        dl_is_write <= !rd_old;
      end
    end
  end

  assign outstanding = cnt_q;
endmodule

// File: rtl/mreq_tracker_chk.sv
module mreq_tracker_chk #(
  parameter int AW         = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_OUT    = 12,
  parameter int ILAT       = 1,
  parameter int CW         = 5,
  parameter int LATW       = 4,
  parameter int LENW       = 7
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [AW-1:0]   req_addr,
  input logic [LENW-1:0] req_len,
  input logic            rsp_valid,
  input logic [1:0]      rsp_status,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic [1:0]      cmd_mode,
  input logic [LATW-1:0] cmd_lat,
  input logic [CW-1:0]   outstanding,
  input logic [CW-1:0]   rd_occ,
  input logic [CW-1:0]   wr_occ,
  input logic            dl_flag
);
  timeunit 1ns; timeprecision 1ps;

  localparam int OFFW = $clog2(LINE_BYTES);
  logic [LENW:0] span;
  assign span = (LENW+1)'(req_addr[OFFW-1:0]) + (LENW+1)'(req_len);

  AST_OCC_SUM: assert property (@(posedge clk) disable iff (rst)
    32'(outstanding) == 32'(rd_occ) + 32'(wr_occ)); // R5
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    32'(outstanding) <= MAX_OUT); // R4
  AST_BAD_SPAN: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (32'(span) > LINE_BYTES)) |=> (rsp_valid && rsp_status == 2'd3)); // R9
  AST_CMD_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (rsp_valid && rsp_status == 2'd0)); // R14
  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid); // R14
  AST_FETCH_LAT: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd0) |-> (32'(cmd_lat) == ILAT)); // R8
  AST_NO_DEVICE_OUT: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_mode != 2'd2)); // R7
  AST_DL_STICKY: assert property (@(posedge clk) disable iff (rst)
    dl_flag |=> dl_flag); // R11
  AST_DEAD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    dl_flag |-> !req_ready); // R12
endmodule

bind mreq_tracker mreq_tracker_chk #(
  .AW(AW), .LINE_BYTES(LINE_BYTES), .MAX_OUT(MAX_OUT), .ILAT(ILAT),
  .CW(CW), .LATW(LATW), .LENW(LENW)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .req_len(req_len), .rsp_valid(rsp_valid),
  .rsp_status(rsp_status), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_mode(cmd_mode), .cmd_lat(cmd_lat), .outstanding(outstanding),
  .rd_occ(rd_occ), .wr_occ(wr_occ), .dl_flag(dl_flag)
);

// File: tb/mreq_tracker_tb_top.sv
module mreq_tracker_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int AW = 32, LB = 64, DEPTH = 4, MAXO = 6, THR = 64;
  localparam int IL = 2, DL = 3, LW = 26, LENW = 7, CW = 4, SCW = 16, LATW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 8 ns period, 125 MHz

  logic            req_valid = 1'b0, req_ready;
  logic [3:0]      req_kind = '0;
  logic [AW-1:0]   req_addr = '0;
  logic [LENW-1:0] req_len = '0;
  logic [1:0]      req_mode = '0;
  logic            rsp_valid, cmd_valid, cpl_err, dl_flag, dl_is_write;
  logic [1:0]      rsp_status, cmd_op, cmd_mode;
  logic [LW-1:0]   cmd_line, dl_line;
  logic [LATW-1:0] cmd_lat;
  logic            cpl_valid = 1'b0, cpl_is_write = 1'b0;
  logic [LW-1:0]   cpl_line = '0;
  logic [CW-1:0]   outstanding;
  logic [SCW-1:0]  stl_wload, stl_wstore, stl_rstore, stl_rload;

  mreq_tracker #(.AW(AW), .LINE_BYTES(LB), .DEPTH(DEPTH), .MAX_OUT(MAXO), .THRESH(THR),
                 .TSW(16), .LATW(LATW), .ILAT(IL), .DLAT(DL), .SCW(SCW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_len(req_len), .req_mode(req_mode),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_line(cmd_line), .cmd_mode(cmd_mode), .cmd_lat(cmd_lat),
    .cpl_valid(cpl_valid), .cpl_line(cpl_line), .cpl_is_write(cpl_is_write),
    .cpl_err(cpl_err), .outstanding(outstanding), .stl_wload(stl_wload),
    .stl_wstore(stl_wstore), .stl_rstore(stl_rstore), .stl_rload(stl_rload),
    .dl_flag(dl_flag), .dl_line(dl_line), .dl_is_write(dl_is_write)
  );

  int nchk = 0, nerr = 0;

  // behavioural reference state
  int rdq[$], rdt[$], wrq[$], wrt[$];
  int m_cnt = 0, now_t = 0, tmr = 0, m_dl_line = 0;
  int mc[4] = '{0, 0, 0, 0};
  bit armed = 0, m_dl = 0, m_dl_wr = 0;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int fnd(input int q[$], input int ln);
    foreach (q[i]) if (q[i] == ln) return i;
    return -1;
  endfunction

  task automatic step(string tag, bit v, int typ, int addr, int len, int mode,
                      bit cv, int cl, bit cw);
    bit take, e_cv, e_err, wrcls;
    int e_st, e_op, e_mode, e_lat, ln, off, k;
    @(negedge clk);
    req_valid = v; req_kind = 4'(typ); req_addr = AW'(addr); req_len = LENW'(len);
    req_mode = 2'(mode); cpl_valid = cv; cpl_line = LW'(cl); cpl_is_write = cw;
    ln = addr / LB; off = addr % LB;
    take = v && !m_dl; e_st = 0; e_cv = 0; e_op = 0; e_mode = 0; e_lat = 0;
    wrcls = typ >= 2;
    if (take) begin
      if (typ > 8 || off + len > LB) e_st = 3;
      else if (fnd(wrq, ln) >= 0) begin
        e_st = 1;
        if (typ == 0 || typ == 1 || typ == 3) mc[0]++; else mc[1]++;
      end else if (fnd(rdq, ln) >= 0) begin
        e_st = 1;
        if (typ == 2 || typ == 4) mc[2]++; else mc[3]++;
      end else if (m_cnt >= MAXO || (wrcls ? wrq.size() : rdq.size()) >= DEPTH) e_st = 2;
      else begin
        e_cv = 1;
        e_op = (typ == 1) ? 0 : (typ == 0) ? 1 : (typ == 5 || typ == 6) ? 3 : 2;
        e_mode = (mode == 1) ? 1 : 0;
        e_lat = (typ == 1) ? IL : DL;
      end
    end
    if (armed && tmr == 0 && !m_dl) begin
      foreach (rdt[i]) if (!m_dl && now_t - rdt[i] >= THR) begin
        m_dl = 1; m_dl_line = rdq[i]; m_dl_wr = 0;
      end
      foreach (wrt[i]) if (!m_dl && now_t - wrt[i] >= THR) begin
        m_dl = 1; m_dl_line = wrq[i]; m_dl_wr = 1;
      end
    end
    e_err = 0;
    if (cv) begin
      k = cw ? fnd(wrq, cl) : fnd(rdq, cl);
      if (k < 0) e_err = 1;
      else begin
        if (cw) begin wrq.delete(k); wrt.delete(k); end
        else begin rdq.delete(k); rdt.delete(k); end
        m_cnt--;
      end
    end
    if (e_cv) begin
      if (wrcls) begin wrq.push_back(ln); wrt.push_back(now_t); end
      else begin rdq.push_back(ln); rdt.push_back(now_t); end
      m_cnt++;
    end
    if (armed && tmr == 0) begin armed = (m_cnt != 0); tmr = THR - 1; end
    else if (armed) tmr--;
    else if (e_cv) begin armed = 1; tmr = THR - 1; end
    now_t++;
    @(posedge clk); #1;
    chk(tag, "rsp_valid", 64'(rsp_valid), 64'(take));
    if (take) chk(tag, "rsp_status", 64'(rsp_status), 64'(e_st));
    chk(tag, "cmd_valid", 64'(cmd_valid), 64'(e_cv));
    if (e_cv) begin
      chk(tag, "cmd_op", 64'(cmd_op), 64'(e_op));
      chk(tag, "cmd_line", 64'(cmd_line), 64'(ln));
      chk(tag, "cmd_mode", 64'(cmd_mode), 64'(e_mode));
      chk(tag, "cmd_lat", 64'(cmd_lat), 64'(e_lat));
    end
    chk(tag, "cpl_err", 64'(cpl_err), 64'(e_err));
    chk(tag, "outstanding", 64'(outstanding), 64'(m_cnt));
    chk(tag, "stl_wload", 64'(stl_wload), 64'(mc[0]));
    chk(tag, "stl_wstore", 64'(stl_wstore), 64'(mc[1]));
    chk(tag, "stl_rstore", 64'(stl_rstore), 64'(mc[2]));
    chk(tag, "stl_rload", 64'(stl_rload), 64'(mc[3]));
    chk(tag, "dl_flag", 64'(dl_flag), 64'(m_dl));
    chk(tag, "req_ready", 64'(req_ready), 64'(!m_dl));
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic drain();
    while (rdq.size() > 0 || wrq.size() > 0) begin
      if (wrq.size() > 0) step("R10", 0, 0, 0, 0, 0, 1, wrq[0], 1);
      else step("R10", 0, 0, 0, 0, 0, 1, rdq[0], 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    chk("R5", "reset outstanding", 64'(outstanding), 64'd0);
    chk("R14", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R12", "reset req_ready", 64'(req_ready), 64'd1);
    chk("R11", "reset dl_flag", 64'(dl_flag), 64'd0);

    // issue one of each class with mode mapping
    step("R6", 1, 0, 'h040, 4, 0, 0, 0, 0);   // load line 1
    step("R8", 1, 1, 'h080, 4, 1, 0, 0, 0);   // fetch line 2
    step("R7", 1, 2, 'h0C0, 8, 2, 0, 0, 0);   // store line 3, device->user
    step("R6", 1, 5, 'h100, 8, 1, 0, 0, 0);   // linked load line 4, atomic
    // aliasing
    step("R2", 1, 0, 'h0C4, 4, 0, 0, 0, 0);   // load on written line
    step("R2", 1, 2, 'h0C8, 4, 0, 0, 0, 0);   // store on written line
    step("R3", 1, 4, 'h044, 4, 0, 0, 0, 0);   // rmw write on read line
    step("R3", 1, 1, 'h048, 4, 0, 0, 0, 0);   // fetch on read line
    // legality boundaries
    step("R9", 1, 0, 'h07C, 8, 0, 0, 0, 0);   // crosses line
    step("R9", 1, 9, 'h200, 4, 0, 0, 0, 0);   // unknown kind
    step("R9", 1, 0, 'h178, 8, 0, 0, 0, 0);   // ends exactly at line end
    // capacity
    step("R4", 1, 0, 'h180, 4, 0, 0, 0, 0);   // count reaches 6
    step("R4", 1, 2, 'h1C0, 4, 0, 0, 0, 0);   // full by count
    step("R10", 0, 0, 0, 0, 0, 1, 6, 0);      // retire line 6
    step("R4", 1, 0, 'h200, 4, 0, 0, 0, 0);   // read table now holds 4
    step("R10", 0, 0, 0, 0, 0, 1, 3, 1);      // retire line 3
    step("R4", 1, 0, 'h240, 4, 0, 0, 0, 0);   // read table full
    step("R1", 1, 7, 'h240, 4, 0, 0, 0, 0);   // locked rmw read to write table
    // bogus completions
    step("R10", 0, 0, 0, 0, 0, 1, 77, 0);
    step("R1", 0, 0, 0, 0, 0, 1, 4, 0);       // wrong class for line 4
    // same-cycle request and retire
    step("R13", 1, 0, 'h244, 4, 0, 1, 9, 1);  // alias with retiring line 9
    step("R13", 1, 3, 'h244, 4, 0, 0, 0, 0);  // now free
    step("R13", 1, 2, 'h280, 4, 0, 1, 1, 0);  // full judged before retire
    step("R5", 1, 2, 'h280, 4, 0, 0, 0, 0);
    drain();
    idle("R5");

    // random overlap phase
    for (int k = 0; k < 3000; k++) begin
      automatic int typ = ($urandom_range(0, 19) == 0) ? 9 : int'($urandom_range(0, 8));
      automatic int ln  = $urandom_range(0, 11);
      automatic int off = $urandom_range(0, 63);
      automatic int len = $urandom_range(1, 8);
      automatic bit v   = $urandom_range(0, 2) != 0;
      automatic bit cv  = $urandom_range(0, 3) != 0;
      automatic bit cw  = $urandom_range(0, 1);
      automatic int cl  = $urandom_range(0, 11);
      if (cw && wrq.size() > 0) cl = wrq[0];
      else if (!cw && rdq.size() > 0) cl = rdq[0];
      step("R13", v, typ, ln * LB + off, len, $urandom_range(0, 3), cv, cl, cw);
    end
    drain();

    // watchdog: leave one write entry stranded
    step("R11", 1, 6, 'h280, 4, 0, 0, 0, 0);
    for (int k = 0; k < 3 * THR && !m_dl; k++) idle("R11");
    chk("R11", "dl_flag raised", 64'(dl_flag), 64'd1);
    chk("R11", "dl_line", 64'(dl_line), 64'd10);
    chk("R11", "dl_is_write", 64'(dl_is_write), 64'd1);
    step("R12", 1, 0, 'h300, 4, 0, 0, 0, 0);
    chk("R12", "ignored request rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R12", "ignored request outstanding", 64'(outstanding), 64'd1);

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule